// File: doc/BRIEF.md
# Bus Privilege Gate with Elevation Doorbell

This unit sits on the bus of an 8-bit processor core that has no privilege logic of its own. It holds one privilege bit, the only record of privilege in the system. It decodes each bus access onto a small group of peripheral pages and drives their chip selects. The pages marked as guarded are selected only while the privilege bit is set. The other pages stay open to all code, so that fast I/O needs no privilege.

A guarded access made without privilege is not aborted. Its select stays low, a write is lost, a read returns 0x00, and a sticky violation flag is set in a status register. The operating system reads this flag on entry to each system call. To ask for elevation, code writes to a doorbell register. The first such write raises a one-cycle NMI request, sets the privilege bit and marks the doorbell as pending. While the doorbell is pending, further doorbell writes are ignored, so the handler works under a global lock. The handler releases the lock and drops privilege through the status register.

Top module: `privGate`

## Requirements
- R1: After reset the privilege bit is 1, the violation flag is 0, no doorbell is pending, `nmiReq` is low and no select is asserted. A status read returns 0x01.
- R2: Peripheral i occupies page SEL_PAGE0+i, where the page is `busAddr[15:8]`. For an open page (PROT_MASK bit i is 0), a valid access asserts `selOut[i]` in the same cycle whatever the privilege, and a read returns `periphRdata`.
- R3: For a guarded page (PROT_MASK bit i is 1) with the privilege bit at 0, `selOut[i]` stays low and a read returns 0x00. With the privilege bit at 1, the page behaves as an open page.
- R4: An unprivileged valid access to a guarded page, or an unprivileged write to the status register, sets the violation flag at the clock edge that ends the access. Privileged accesses never set it.
- R5: The violation flag is sticky. Only a privileged status write with bit 1 = 1 clears it. Unprivileged writes leave it set.
- R6: A doorbell write (any data, control page CTRL_PAGE, offset 1) made while no doorbell is pending does three things. It drives `nmiReq` high for exactly the one cycle after the edge that ends the write. It sets the privilege bit. It sets the pending bit.
- R7: A doorbell write made while a doorbell is pending produces no `nmiReq` pulse and changes no state.
- R8: A privileged write to the status register (control page, offset 0) clears the pending bit when bit 2 = 1 and clears the privilege bit when bit 0 = 0. No status write ever sets either bit. Unprivileged status writes change neither bit.
- R9: A status read (control page, offset 0) is allowed at any privilege. It returns bit 0 = privilege, bit 1 = violation, bit 2 = pending and 0 in bits 7:3. A valid read of any other address that selects nothing returns 0x00.
- R10: With `busValid` low, no select is asserted and no state changes. At most one select is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Access strobe for the current cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 16 | Byte address |
| busWdata | input | 8 | Write data |
| periphRdata | input | 8 | Read data from the selected peripheral |
| busRdata | output | 8 | Read data returned to the core |
| selOut | output | 4 | Gated peripheral chip selects, one per page |
| nmiReq | output | 1 | One-cycle NMI request from the doorbell |

## Verification
The selects and the read data are combinational from the bus and the held privilege bit. The bench therefore samples them within the same cycle, 1 ns after it drives the inputs at the falling edge. The privilege, violation and pending bits change at the rising edge that ends an access. They are observed through a status read in a later cycle. `nmiReq` is due in the cycle after the edge that takes the doorbell, so the bench compares it one access later against the pulse predicted for the previous cycle. A cycle-level model in the bench holds the three state bits and predicts every output of every access, including whole sweeps of all pages with and without privilege.

// File: rtl/privGatePkg.sv
package privGatePkg;

  // register offsets inside the control page
  localparam int STATUS_OFF = 0;
  localparam int BELL_OFF   = 1;

  // status byte bit positions (software decodes these)
  localparam int PRIV_BIT = 0;
  localparam int VIOL_BIT = 1;
  localparam int PEND_BIT = 2;

  localparam int DATA_W = 8;

  // strobes from decode/control to the state datapath
  typedef struct packed {
    logic statusRd;   // valid read of the status register
    logic statusWr;   // privileged write of the status register
    logic bellWr;     // doorbell write, any privilege
    logic periphRd;   // read of a page that is allowed this cycle
    logic violSet;    // access that breaks privilege
  } gateStrobeT;

endpackage

// File: rtl/privGateCtrl.sv
module privGateCtrl
  import privGatePkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int OFFS_W    = 8,
  parameter int NUM_SEL   = 4,
  parameter int SEL_PAGE0 = 'hD0,
  parameter int CTRL_PAGE = 'hDF,
  parameter logic [NUM_SEL-1:0] PROT_MASK = 4'b0101
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busValid,
  input  logic               busWrite,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               privNow,
  output logic [NUM_SEL-1:0] selOut,
  output gateStrobeT         strobe
);

  localparam int PAGE_W = ADDR_W - OFFS_W;

  logic [PAGE_W-1:0]  pageNum;
  logic [OFFS_W-1:0]  offNum;
  logic [NUM_SEL-1:0] pageHit;
  logic [NUM_SEL-1:0] allowHit;
  logic               guardMiss;
  logic               ctrlHit;
  logic               statusHit;
  logic               bellHit;

  assign pageNum = busAddr[ADDR_W-1:OFFS_W];
  assign offNum  = busAddr[OFFS_W-1:0];

  for (genvar i = 0; i < NUM_SEL; i++) begin : g_page
    assign pageHit[i]  = (pageNum == PAGE_W'(SEL_PAGE0 + i));
    if (PROT_MASK[i]) begin : g_guarded
      assign allowHit[i] = pageHit[i] & privNow;
    end else begin : g_open
      assign allowHit[i] = pageHit[i];
    end
    assign selOut[i] = busValid & allowHit[i];
  end

  assign guardMiss = |(pageHit & PROT_MASK) & ~privNow;
  assign ctrlHit   = (pageNum == PAGE_W'(CTRL_PAGE));
  assign statusHit = ctrlHit & (offNum == OFFS_W'(STATUS_OFF));
  assign bellHit   = ctrlHit & (offNum == OFFS_W'(BELL_OFF));

  always_comb begin
    strobe          = '0;
    strobe.statusRd = busValid & ~busWrite & statusHit;
    strobe.statusWr = busValid &  busWrite & statusHit & privNow;
    strobe.bellWr   = busValid &  busWrite & bellHit;
    strobe.periphRd = busValid & ~busWrite & (|allowHit);
    strobe.violSet  = busValid & (guardMiss | (busWrite & statusHit & ~privNow));
  end

  // R10: at most one select, none while idle
  p_one_sel_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(selOut));
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !busValid |-> (selOut == '0) && !strobe.violSet);
  // R3/R4: a guarded page touched without privilege flags a violation and asserts no select
  p_guard_flag_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && |(pageHit & PROT_MASK) && !privNow) |-> strobe.violSet && ((selOut & PROT_MASK) == '0));

endmodule

// File: rtl/privGateData.sv
module privGateData
  import privGatePkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  gateStrobeT        strobe,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] periphRdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              privNow,
  output logic              nmiReq
);

  logic privQ;
  logic violQ;
  logic pendQ;
  logic nmiQ;
  logic takeBell;
  logic [DATA_W-1:0] statusByte;

  assign takeBell = strobe.bellWr & ~pendQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      privQ <= 1'b1;
      violQ <= 1'b0;
      pendQ <= 1'b0;
      nmiQ  <= 1'b0;
    end else begin
      nmiQ <= takeBell;
      if (takeBell) begin
        pendQ <= 1'b1;
        privQ <= 1'b1;
      end else if (strobe.statusWr) begin
        if (busWdata[PEND_BIT])  pendQ <= 1'b0;
        if (!busWdata[PRIV_BIT]) privQ <= 1'b0;
      end
      if (strobe.violSet)
        violQ <= 1'b1;
      else if (strobe.statusWr && busWdata[VIOL_BIT])
        violQ <= 1'b0;
    end
  end

  always_comb begin
    statusByte           = '0;
    statusByte[PRIV_BIT] = privQ;
    statusByte[VIOL_BIT] = violQ;
    statusByte[PEND_BIT] = pendQ;
  end

  assign busRdata = strobe.statusRd ? statusByte :
                    strobe.periphRd ? periphRdata : '0;
  assign privNow  = privQ;
  assign nmiReq   = nmiQ;

  // R6: request lasts one cycle and always comes with a held lock
  p_nmi_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    nmiReq |=> !nmiReq);
  p_nmi_locked_r6: assert property (@(posedge clk) disable iff (!rstN)
    nmiReq |-> pendQ && privQ);
  // R6: privilege only rises together with a doorbell pulse
  p_priv_rise_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(privQ) |-> nmiReq);
  // R7: no fresh pulse while the lock is held
  p_lock_held_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pendQ && !strobe.statusWr) |=> pendQ && !nmiReq);
  // R5: violation flag survives anything but a privileged clear
  p_viol_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    (violQ && !strobe.statusWr) |=> violQ);

endmodule

// File: rtl/privGate.sv
module privGate
  import privGatePkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int OFFS_W    = 8,
  parameter int NUM_SEL   = 4,
  parameter int SEL_PAGE0 = 'hD0,
  parameter int CTRL_PAGE = 'hDF,
  parameter logic [NUM_SEL-1:0] PROT_MASK = 4'b0101
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busValid,
  input  logic               busWrite,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [7:0]         busWdata,
  input  logic [7:0]         periphRdata,
  output logic [7:0]         busRdata,
  output logic [NUM_SEL-1:0] selOut,
  output logic               nmiReq
);

  gateStrobeT strobe;
  logic       privNow;

  privGateCtrl #(
    .ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .NUM_SEL(NUM_SEL),
    .SEL_PAGE0(SEL_PAGE0), .CTRL_PAGE(CTRL_PAGE), .PROT_MASK(PROT_MASK)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .privNow(privNow), .selOut(selOut), .strobe(strobe)
  );

  privGateData u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .busWdata(busWdata), .periphRdata(periphRdata),
    .busRdata(busRdata), .privNow(privNow), .nmiReq(nmiReq)
  );

endmodule

// File: tb/privGate_tb.sv
`timescale 1ns/1ps
module privGate_tb;

  localparam int NUM_SEL   = 4;
  localparam int SEL_PAGE0 = 'hD0;
  localparam int CTRL_PAGE = 'hDF;
  localparam logic [NUM_SEL-1:0] PROT_MASK = 4'b0101;

  logic clk = 1'b0;
  logic rstN;
  logic busValid, busWrite;
  logic [15:0] busAddr;
  logic [7:0]  busWdata, periphRdata, busRdata;
  logic [NUM_SEL-1:0] selOut;
  logic nmiReq;

  always #2 clk = ~clk;

  privGate u_dut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .periphRdata(periphRdata),
    .busRdata(busRdata), .selOut(selOut), .nmiReq(nmiReq)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit mPriv, mViol, mPend, mNmi;
  logic [7:0] lastRd;
  logic       lastNmi;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  // one bus cycle: drive at falling edge, check 1 ns later, advance the model
  task automatic cycle(input bit v, input bit w, input logic [15:0] a, input logic [7:0] d);
    int pg, idx;
    bit inR, prot, allow, isCtrl, stWr, bell, vset;
    logic [NUM_SEL-1:0] eSel;
    logic [7:0] eRd;
    string rq;
    @(negedge clk);
    busValid = v; busWrite = w; busAddr = a; busWdata = d;
    periphRdata = a[15:8] ^ 8'hA5;
    #1;
    pg = int'(a[15:8]);
    inR = (pg >= SEL_PAGE0) && (pg < SEL_PAGE0 + NUM_SEL);
    idx = inR ? pg - SEL_PAGE0 : 0;
    prot = inR && PROT_MASK[idx];
    allow = inR && (!prot || mPriv);
    isCtrl = (pg == CTRL_PAGE);
    eSel = (v && allow) ? NUM_SEL'(1 << idx) : '0;
    eRd = 8'h00;
    if (v && !w) begin
      if (isCtrl && a[7:0] == 8'h00) eRd = {5'b0, mPend, mViol, mPriv};
      else if (allow) eRd = a[15:8] ^ 8'hA5;
    end
    rq = !v ? "R10" : (inR ? (prot ? "R3" : "R2") : (isCtrl ? "R9" : "R10"));
    chk({rq, " select"}, 32'(selOut), 32'(eSel));
    chk({rq, " read data"}, 32'(busRdata), 32'(eRd));
    chk(mPend ? "R7 nmi" : "R6 nmi", 32'(nmiReq), 32'(mNmi));
    lastRd = busRdata;
    lastNmi = nmiReq;
    stWr = v && w && isCtrl && a[7:0] == 8'h00;
    bell = v && w && isCtrl && a[7:0] == 8'h01;
    vset = v && ((prot && !mPriv) || (stWr && !mPriv));
    mNmi = bell && !mPend;
    if (bell && !mPend) begin
      mPend = 1'b1; mPriv = 1'b1;
    end else if (stWr && mPriv) begin
      if (d[2]) mPend = 1'b0;
      if (!d[0]) mPriv = 1'b0;
    end
    if (vset) mViol = 1'b1;
    else if (stWr && mPriv && d[1]) mViol = 1'b0;
  endtask

  task automatic idle();
    cycle(1'b0, 1'b0, 16'h0000, 8'h00);
  endtask

  task automatic expectStatus(input string req, input logic [7:0] exp);
    cycle(1'b1, 1'b0, {8'(CTRL_PAGE), 8'h00}, 8'h00);
    chk({req, " status"}, 32'(lastRd), 32'(exp));
  endtask

  task automatic statusWrite(input logic [7:0] d);
    cycle(1'b1, 1'b1, {8'(CTRL_PAGE), 8'h00}, d);
  endtask

  task automatic bell();
    cycle(1'b1, 1'b1, {8'(CTRL_PAGE), 8'h01}, 8'h3C);
  endtask

  task automatic sweep();
    for (int pg = 0; pg < 256; pg++) begin
      if (pg == CTRL_PAGE) continue;
      for (int w = 0; w < 2; w++)
        cycle(1'b1, w[0], {8'(pg), 8'(pg * 7)}, 8'(pg + w));
    end
  endtask

  initial begin
    #(4 * 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    busValid = 0; busWrite = 0; busAddr = '0; busWdata = '0; periphRdata = '0;
    mPriv = 1; mViol = 0; mPend = 0; mNmi = 0;
    rstN = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    #1;
    // R1 reset state
    chk("R1 selects", 32'(selOut), 32'h0);
    chk("R1 nmi", 32'(nmiReq), 32'h0);
    expectStatus("R1", 8'h01);

    // R2/R3 sweep with privilege, R4 no flag
    sweep();
    expectStatus("R4 privileged sweep", 8'h01);

    // R8 drop privilege
    statusWrite(8'h00);
    expectStatus("R8 drop", 8'h00);

    // R2/R3 sweep without privilege, R4 flag set
    sweep();
    expectStatus("R4 unprivileged sweep", 8'h02);

    // R10 idle on guarded pages
    for (int i = 0; i < NUM_SEL; i++)
      cycle(1'b0, 1'b1, {8'(SEL_PAGE0 + i), 8'h10}, 8'hFF);

    // R5/R8 unprivileged status write changes nothing
    statusWrite(8'h07);
    expectStatus("R5 R8 unprivileged write", 8'h02);

    // R6 doorbell
    bell();
    idle();
    chk("R6 pulse", 32'(lastNmi), 32'h1);
    idle();
    chk("R6 pulse ends", 32'(lastNmi), 32'h0);
    expectStatus("R6", 8'h07);

    // R7 doorbell while pending
    bell();
    idle();
    chk("R7 no pulse", 32'(lastNmi), 32'h0);
    expectStatus("R7", 8'h07);

    // R5 privileged clear of violation
    statusWrite(8'h03);
    expectStatus("R5 clear", 8'h05);

    // R8 release lock and drop privilege together
    statusWrite(8'h04);
    expectStatus("R8 release", 8'h00);

    // R6 back to back doorbells give one pulse
    bell();
    bell();
    idle();
    chk("R7 second bell", 32'(lastNmi), 32'h0);
    expectStatus("R6 second entry", 8'h05);
    statusWrite(8'h05);
    expectStatus("R8 keep privilege", 8'h01);
    bell();
    idle();
    chk("R6 pulse again", 32'(lastNmi), 32'h1);

    summary();
    $finish;
  end

endmodule